// File: doc/BRIEF.md
# Audio Master Clock Ratio Detector

This block sits beside an audio converter. It watches the frame (left/right) clock and the bit clock against a free-running master clock that is synchronous with them. It counts the master cycles between successive rising frame edges. It then decides which of five oversampling ratios is present: 256, 384, 512, 768 or 1024. After the same ratio has been measured several frames in a row, it declares lock.

While locked, the block produces a single-cycle clock enable that fires exactly 256 times per frame, whatever the ratio is. Downstream converter logic can therefore run on one uniform 256fs time base. A separate flag asks the modulator for its doubled oversampling rate, and it is raised only for the 1024 ratio. The block also asks for muted samples whenever it is not locked, flags a frame clock that has stopped, and reports whether the bit clock runs at 32 or 64 edges per frame. The detected ratio code is exposed so that logic above the block can reject the 1024 ratio at frame rates above 25 kHz.

Top module: `mclk_ratio_detect`

## Requirements
- R1: A measured frame period within ±2 master cycles of a nominal ratio sets `ratioValid` high and `ratioCode` to that ratio's code. The codes are 0=256, 1=384, 2=512, 3=768 and 4=1024. The measurement is taken at each rising frame edge and covers the preceding frame.
- R2: A measured period that is more than 2 cycles away from every nominal ratio clears `ratioValid` and `locked` at that frame edge.
- R3: `locked` rises only once the same valid ratio has been measured on 4 consecutive frames. With 3 such measurements it is still low.
- R4: A measured ratio that differs from the held ratio clears `locked` at that frame edge. `muteReq` is high exactly when `locked` is low.
- R5: While locked, `en256` is high on exactly 256 master cycles in every frame of nominal length, for every ratio. While not locked, `en256` stays low.
- R6: `osr256Sel` is high only while the block is locked on ratio code 4 (1024). For any other locked ratio it is low.
- R7: If 2048 master cycles pass without a rising frame edge, `frameMissing` is raised, and `locked` and `ratioValid` are cleared. The next rising frame edge clears `frameMissing`.
- R8: At each frame edge, `bclk64` is set to 1 if the previous frame held at least 48 rising bit clock edges (64fs), and to 0 otherwise (32fs).
- R9: Only rising frame edges are used. The frame clock's high time and its position within the master period do not affect the detected ratio or the lock.
- R10: During reset, `ratioValid`, `locked`, `en256`, `osr256Sel`, `frameMissing` and `bclk64` are low, and `muteReq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameClk | input | 1 | Frame (left/right) clock, synchronous to clk |
| bitClk | input | 1 | Serial bit clock, synchronous to clk |
| ratioCode | output | 3 | Detected ratio code (0=256, 1=384, 2=512, 3=768, 4=1024) |
| ratioValid | output | 1 | Last measured period matched a ratio |
| locked | output | 1 | Ratio stable over the required number of frames |
| en256 | output | 1 | Clock enable at 256 times the frame rate |
| osr256Sel | output | 1 | Selects the doubled modulator oversampling rate |
| frameMissing | output | 1 | No frame edge within the timeout |
| bclk64 | output | 1 | Bit clock measured at 64 edges per frame |
| muteReq | output | 1 | Request to force converter samples to zero |

## Verification
The bench builds the block with its default parameters: a ±2 cycle tolerance, a 4-frame lock streak, a 2048-cycle frame timeout and a 48-edge bit clock split. With these values, every ratio up to 1024 cycles fits inside the timeout, so a stopped frame clock can be shown within about two thousand cycles. Exact period boundaries at +2 and −3 are exercised, as is the change from lock on 1024 to 768. Random trials mix ratio, jitter, duty cycle and bit clock rate, and each trial ends with an exact count of enables over one frame.

// File: rtl/mclkdet_pkg.sv
package mclkdet_pkg;

  localparam int unsigned NUM_RATIOS = 5;
  localparam int unsigned EN_PER_FRAME = 256;
  localparam int unsigned MAX_NOMINAL = 1024;

  typedef enum logic [2:0] {
    RATIO_256  = 3'd0,
    RATIO_384  = 3'd1,
    RATIO_512  = 3'd2,
    RATIO_768  = 3'd3,
    RATIO_1024 = 3'd4
  } ratio_e;

  typedef struct packed {
    logic   ok;
    ratio_e code;
  } measure_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   frameRise;
    logic   run;
    ratio_e code;
  } ctrlStrobe_t;

  function automatic int unsigned nominalOf(ratio_e code);
    case (code)
      RATIO_384:  return 384;
      RATIO_512:  return 512;
      RATIO_768:  return 768;
      RATIO_1024: return 1024;
      default:    return 256;
    endcase
  endfunction

  function automatic measure_t classifyPeriod(int unsigned period, int unsigned tol);
    measure_t r;
    int unsigned nom;
    r.ok = 1'b0;
    r.code = RATIO_256;
    for (int k = 0; k < int'(NUM_RATIOS); k++) begin
      nom = nominalOf(ratio_e'(k[2:0]));
      if ((period + tol >= nom) && (period <= nom + tol)) begin
        r.ok = 1'b1;
        r.code = ratio_e'(k[2:0]);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/mclkdet_ctrl.sv
module mclkdet_ctrl
  import mclkdet_pkg::*;
#(
  parameter int unsigned TOL         = 2,
  parameter int unsigned LOCK_FRAMES = 4,
  parameter int unsigned MISS_LIMIT  = 2048,
  parameter int unsigned BCLK_SPLIT  = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameClk,
  input  logic        bitClk,
  output ctrlStrobe_t strobe,
  output ratio_e      ratioCode,
  output logic        ratioValid,
  output logic        locked,
  output logic        frameMissing,
  output logic        bclk64
);

  localparam int unsigned CNT_W    = $clog2(MISS_LIMIT + 1);
  localparam int unsigned STREAK_W = $clog2(LOCK_FRAMES + 1);

  logic                frameQ, bitQ, haveEdge;
  logic [CNT_W-1:0]    periodCnt, bitCnt;
  logic [STREAK_W-1:0] streak, nextStreak;
  logic                frameRise, bitRise, sameRatio, missHit;
  measure_t            meas;

  assign frameRise = frameClk & ~frameQ;
  assign bitRise   = bitClk & ~bitQ;
  assign meas      = classifyPeriod(int'(periodCnt), TOL);
  assign sameRatio = meas.ok && ratioValid && (meas.code == ratioCode);
  assign missHit   = !frameRise && (periodCnt == CNT_W'(MISS_LIMIT));

  always_comb begin
    if (!meas.ok)                                   nextStreak = '0;
    else if (!sameRatio)                            nextStreak = STREAK_W'(1);
    else if (streak < STREAK_W'(LOCK_FRAMES))       nextStreak = streak + 1'b1;
    else                                            nextStreak = streak;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ       <= 1'b0;
      bitQ         <= 1'b0;
      haveEdge     <= 1'b0;
      periodCnt    <= '0;
      bitCnt       <= '0;
      streak       <= '0;
      ratioCode    <= RATIO_256;
      ratioValid   <= 1'b0;
      locked       <= 1'b0;
      frameMissing <= 1'b0;
      bclk64       <= 1'b0;
    end else begin
      frameQ <= frameClk;
      bitQ   <= bitClk;
      if (frameRise) begin
        periodCnt    <= CNT_W'(1);
        bitCnt       <= bitRise ? CNT_W'(1) : '0;
        haveEdge     <= 1'b1;
        frameMissing <= 1'b0;
        if (haveEdge) begin
          ratioValid <= meas.ok;
          if (meas.ok) ratioCode <= meas.code;
          streak <= nextStreak;
          locked <= (nextStreak >= STREAK_W'(LOCK_FRAMES));
          bclk64 <= (bitCnt >= CNT_W'(BCLK_SPLIT));
        end
      end else begin
        if (periodCnt != CNT_W'(MISS_LIMIT)) periodCnt <= periodCnt + 1'b1;
        if (bitRise && bitCnt != CNT_W'(MISS_LIMIT)) bitCnt <= bitCnt + 1'b1;
        if (missHit) begin
          frameMissing <= 1'b1;
          locked       <= 1'b0;
          ratioValid   <= 1'b0;
          streak       <= '0;
        end
      end
    end
  end

  assign strobe.frameRise = frameRise;
  assign strobe.run       = locked;
  assign strobe.code      = ratioCode;

  p_invalid_unlocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (frameRise && haveEdge && !meas.ok) |=> (!locked && !ratioValid));

  p_lock_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> ratioValid);

  p_change_unlocks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (frameRise && haveEdge && meas.ok && ratioValid && meas.code != ratioCode) |=> !locked);

  p_missing_unlocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameMissing |-> !locked);

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    periodCnt <= CNT_W'(MISS_LIMIT));

endmodule

// File: rtl/mclkdet_datapath.sv
module mclkdet_datapath
  import mclkdet_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output logic        en256,
  output logic        osr256Sel
);

  localparam int unsigned ACC_W = $clog2(MAX_NOMINAL + EN_PER_FRAME + 1);

  logic [ACC_W-1:0] acc, accBase, accSum, nominal;

  assign nominal = ACC_W'(nominalOf(strobe.code));
  assign accBase = strobe.frameRise ? '0 : acc;
  assign accSum  = accBase + ACC_W'(EN_PER_FRAME);

  // fractional accumulator: add 256 per master cycle, wrap at the ratio
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      en256     <= 1'b0;
      osr256Sel <= 1'b0;
    end else begin
      osr256Sel <= strobe.run && (strobe.code == RATIO_1024);
      if (!strobe.run) begin
        acc   <= '0;
        en256 <= 1'b0;
      end else if (accSum >= nominal) begin
        acc   <= accSum - nominal;
        en256 <= 1'b1;
      end else begin
        acc   <= accSum;
        en256 <= 1'b0;
      end
    end
  end

  p_acc_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (acc < nominal));

  p_en_needs_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    en256 |-> $past(strobe.run));

  p_osr_only_1024_r6: assert property (@(posedge clk) disable iff (!rstN)
    osr256Sel |-> ($past(strobe.run) && $past(strobe.code) == RATIO_1024));

endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mclkdet_pkg::*;
#(
  parameter int unsigned TOL         = 2,
  parameter int unsigned LOCK_FRAMES = 4,
  parameter int unsigned MISS_LIMIT  = 2048,
  parameter int unsigned BCLK_SPLIT  = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameClk,
  input  logic       bitClk,
  output logic [2:0] ratioCode,
  output logic       ratioValid,
  output logic       locked,
  output logic       en256,
  output logic       osr256Sel,
  output logic       frameMissing,
  output logic       bclk64,
  output logic       muteReq
);

  ctrlStrobe_t strobe;
  ratio_e      codeE;

  mclkdet_ctrl #(
    .TOL(TOL), .LOCK_FRAMES(LOCK_FRAMES), .MISS_LIMIT(MISS_LIMIT), .BCLK_SPLIT(BCLK_SPLIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .frameClk(frameClk), .bitClk(bitClk),
    .strobe(strobe), .ratioCode(codeE), .ratioValid(ratioValid),
    .locked(locked), .frameMissing(frameMissing), .bclk64(bclk64)
  );

  mclkdet_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .en256(en256), .osr256Sel(osr256Sel)
  );

  assign ratioCode = codeE;
  assign muteReq   = !locked;

endmodule

// File: tb/mclk_ratio_detect_tb.sv
module mclk_ratio_detect_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic clk = 1'b0, rstN = 1'b0, frameClk = 1'b0, bitClk = 1'b0;
  logic [2:0] ratioCode;
  logic ratioValid, locked, en256, osr256Sel, frameMissing, bclk64, muteReq;

  int checks = 0, errors = 0, cycles = 0;

  mclk_ratio_detect u_dut (
    .clk(clk), .rstN(rstN), .frameClk(frameClk), .bitClk(bitClk),
    .ratioCode(ratioCode), .ratioValid(ratioValid), .locked(locked), .en256(en256),
    .osr256Sel(osr256Sel), .frameMissing(frameMissing), .bclk64(bclk64), .muteReq(muteReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCode(int n);
    case (n)
      384: return 1;
      512: return 2;
      768: return 3;
      1024: return 4;
      default: return 0;
    endcase
  endfunction

  // one frame of 'period' cycles; returns the number of enables seen
  task automatic driveFrame(int period, int bitDiv, int highLen, output int ens);
    ens = 0;
    for (int i = 0; i < period; i++) begin
      @(negedge clk);
      ens += int'(en256);
      frameClk = (i < highLen);
      bitClk = ((i % bitDiv) < bitDiv / 2);
    end
  endtask

  task automatic frames(int count, int period, int bitDiv, int highLen, output int ens);
    for (int f = 0; f < count; f++) driveFrame(period, bitDiv, highLen, ens);
  endtask

  task automatic quiet(int n, output int ens);
    ens = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ens += int'(en256);
      frameClk = 1'b0;
      bitClk = 1'b0;
    end
  endtask

  initial begin
    while (cycles < WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ens;
    void'($urandom(32'h1A2B3C));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid", ratioValid, 0);
    chk("R10 locked", locked, 0);
    chk("R10 en256", en256, 0);
    chk("R10 osr", osr256Sel, 0);
    chk("R10 missing", frameMissing, 0);
    chk("R10 bclk64", bclk64, 0);
    chk("R10 mute", muteReq, 1);
    rstN = 1'b1;

    // R3: 384, 64fs, half duty
    frames(4, 384, 6, 192, ens);
    chk("R3 not yet locked", locked, 0);
    chk("R1 code 384", ratioCode, 1);
    chk("R1 valid", ratioValid, 1);
    frames(1, 384, 6, 192, ens);
    chk("R3 locked after 4", locked, 1);
    chk("R4 mute released", muteReq, 0);
    frames(2, 384, 6, 192, ens);
    chk("R5 enables 384", ens, 256);
    chk("R6 osr low at 384", osr256Sel, 0);
    chk("R8 bclk 64fs", bclk64, 1);

    // R9 narrow pulse, 1024, 32fs
    frames(7, 1024, 32, 1, ens);
    chk("R9 code 1024 narrow pulse", ratioCode, 4);
    chk("R9 locked narrow pulse", locked, 1);
    chk("R6 osr high at 1024", osr256Sel, 1);
    chk("R8 bclk 32fs", bclk64, 0);
    chk("R5 enables 1024", ens, 256);

    // R4 change 1024 -> 768
    frames(1, 768, 12, 700, ens);
    chk("R4 still locked", locked, 1);
    frames(1, 768, 12, 700, ens);
    chk("R4 change unlocks", locked, 0);
    chk("R4 mute on change", muteReq, 1);
    chk("R1 code 768", ratioCode, 3);
    chk("R6 osr low after change", osr256Sel, 0);

    // R1 tolerance boundary +2, R2 outside
    frames(6, 514, 8, 257, ens);
    chk("R1 +2 accepted", ratioCode, 2);
    chk("R1 +2 locks", locked, 1);
    frames(1, 509, 8, 250, ens);
    frames(1, 512, 8, 256, ens);
    chk("R2 -3 invalid", ratioValid, 0);
    chk("R2 -3 unlocks", locked, 0);
    frames(6, 512, 8, 256, ens);
    frames(1, 515, 8, 256, ens);
    frames(1, 512, 8, 256, ens);
    chk("R2 +3 invalid", ratioValid, 0);

    // R7 missing frame
    frames(6, 256, 4, 128, ens);
    chk("R7 locked before gap", locked, 1);
    quiet(1000, ens);
    chk("R7 no flag before limit", frameMissing, 0);
    chk("R7 lock held before limit", locked, 1);
    quiet(1200, ens);
    chk("R7 flag raised", frameMissing, 1);
    chk("R7 lock dropped", locked, 0);
    chk("R7 valid dropped", ratioValid, 0);
    chk("R4 mute while missing", muteReq, 1);
    quiet(50, ens);
    chk("R5 no enables unlocked", ens, 0);
    frames(1, 256, 4, 128, ens);
    chk("R7 flag cleared", frameMissing, 0);

    // random trials
    for (int t = 0; t < 8; t++) begin
      int idx, n, b64, div, exp;
      idx = int'($urandom % 5);
      n = (idx == 0) ? 256 : (idx == 1) ? 384 : (idx == 2) ? 512 : (idx == 3) ? 768 : 1024;
      b64 = int'($urandom % 2);
      div = b64 != 0 ? n / 64 : n / 32;
      for (int f = 0; f < 6; f++) begin
        int p;
        p = n + int'($urandom % 5) - 2;
        driveFrame(p, div, 1 + int'($urandom % (p - 1)), ens);
      end
      exp = expCode(n);
      chk("R1 random code", ratioCode, exp);
      chk("R3 random lock", locked, 1);
      chk("R6 random osr", osr256Sel, (n == 1024) ? 1 : 0);
      chk("R8 random bclk", bclk64, b64);
      frames(2, n, div, 1 + int'($urandom % (n - 1)), ens);
      chk("R5 random enables", ens, 256);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule